// File: doc/BRIEF.md
# Dual Down-Counter Timer Peripheral

This block places several independent down-counting timers behind one 4 KB register window and adds a small read-only identification area at the top of that window. Each timer owns a 32-byte bank. A timer steps only when its own clock-enable input is high, so each timer can run at a different rate without any clock of its own. Each timer divides its enable stream by 1, 16 or 256 and counts down in 16-bit or 32-bit width. It either reloads, wraps to all ones, or halts when it reaches zero.

Each timer latches an interrupt when its count falls from one to zero. Each timer's enabled interrupt is brought out on its own pin, and the OR of all of them drives one combined pin. The bus is a simple single-cycle port. Writes take effect at the clock edge. Read data is combinational and is zero when the port is not selected. Offsets that map to nothing, including the two integration-test words, read as zero and ignore writes.

Top module: `dt_dual_timer`

## Requirements
- R1: After reset every timer's control word reads 0x20 (interrupt enable set, all else clear), its load and count read 0, and every interrupt output is low.
- R2: Timer n occupies byte offsets 0x20*n to 0x20*n+0x1F. The words within a bank are: 0x00 load (a write sets both load and count), 0x04 count (read-only), 0x08 control, 0x0C interrupt clear, 0x10 raw interrupt, 0x14 masked interrupt, 0x18 background load (a write sets load only; reads return load).
- R3: A write to one timer's bank changes no register of any other timer.
- R4: Offsets 0xFE0 to 0xFFC return identification byte (offset-0xFE0)>>2 in bits 7:0 with bits 31:8 zero. Bytes 0 to 3 are parameters (defaults 0x04, 0x18, 0x14, 0x00). Bytes 4 to 7 are 0x0D, 0xF0, 0x05, 0xB1.
- R5: Reads from unmapped offsets, including 0xF00 and 0xF04, return zero. Writes to unmapped offsets or to the identification area change nothing.
- R6: Control bits are: bit 7 run, bit 6 periodic, bit 5 interrupt enable, bits 3:2 prescale, bit 1 32-bit width, bit 0 one-shot. A step decrements the count, and a step from 1 to 0 sets the raw interrupt.
- R7: A step taken at count zero loads the load value in periodic mode. In free-running mode it loads all ones of the current width (0xFFFF or 0xFFFFFFFF). In one-shot mode the count stays at zero.
- R8: Prescale 0 steps on every enabled tick, prescale 1 on every 16th and prescale 2 on every 256th. Counting restarts on each control write.
- R9: A timer whose tick-enable input is low keeps its count, and it raises no interrupt without a tick or a bus write.
- R10: The masked interrupt equals raw AND interrupt enable. Each per-timer output carries its timer's masked interrupt. The combined output is the OR of all of them.
- R11: A write of any value to the interrupt-clear word clears that timer's raw interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| tick_en | input | N_TIMERS | Per-timer step enable |
| irq_each | output | N_TIMERS | Per-timer masked interrupt |
| irq_comb | output | 1 | OR of all masked interrupts |

## Verification
The bench builds the block with two timers. It overrides the four parameter identification bytes with 0xA1, 0xB2, 0xC3 and 0xD4, so a readback that matches shows those parameters reach the bus and are not mixed up with the fixed bytes. With two timers the bank at 0x40 is unmapped, which lets the bench check that a third bank does not alias onto the first. The small default prescale divisors keep the /16 boundary within a few dozen cycles.

// File: rtl/dt_pkg.sv
package dt_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 12;
    localparam int WORD_LSB   = 2;
    localparam int BANK_LSB   = 5;
    localparam int BANK_W     = ADDR_W - BANK_LSB;
    localparam int WIN_STRIDE = 1 << BANK_LSB;
    localparam logic [BANK_W-1:0] ID_BANK = '1;

    typedef enum logic [2:0] {
        W_LOAD   = 3'd0,
        W_COUNT  = 3'd1,
        W_CTRL   = 3'd2,
        W_CLEAR  = 3'd3,
        W_RAW    = 3'd4,
        W_MASKED = 3'd5,
        W_BGLOAD = 3'd6,
        W_NONE   = 3'd7
    } word_e;

    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       ie;
        logic       spare;
        logic [1:0] psc;
        logic       wide;
        logic       oneshot;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = ctrl_t'(8'h20);

    function automatic logic [7:0] presc_mask(input logic [1:0] psc);
        case (psc)
            2'd1:    return 8'h0F;
            2'd2:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic wide);
        return wide ? {DATA_W{1'b1}} : {{(DATA_W-16){1'b0}}, 16'hFFFF};
    endfunction

    function automatic logic [7:0] id_lookup(input logic [2:0] idx,
                                             input logic [31:0] part);
        case (idx)
            3'd0:    return part[7:0];
            3'd1:    return part[15:8];
            3'd2:    return part[23:16];
            3'd3:    return part[31:24];
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/dt_timer_core.sv
module dt_timer_core
    import dt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  word_e             word,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] count,
    output logic              irq
);

    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] count_q;
    ctrl_t             ctrl_q;
    logic              raw_q;
    logic [7:0]        presc_q;

    logic [DATA_W-1:0] wmask;
    logic [7:0]        pmask;
    logic [DATA_W-1:0] count_m;
    logic [DATA_W-1:0] reload_val;
    logic              step;
    logic              wr_ctrl;

    assign wmask      = width_mask(ctrl_q.wide);
    assign pmask      = presc_mask(ctrl_q.psc);
    assign count_m    = count_q & wmask;
    assign reload_val = ctrl_q.periodic ? (load_q & wmask) : wmask;
    assign step       = tick && ctrl_q.run && ((presc_q & pmask) == pmask);
    assign wr_ctrl    = wr_en && (word == W_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q  <= '0;
            count_q <= '0;
            ctrl_q  <= CTRL_RESET;
            raw_q   <= 1'b0;
            presc_q <= '0;
        end else begin
            if (wr_ctrl) begin
                presc_q <= '0;
                ctrl_q  <= ctrl_t'(wdata[7:0]);
            end else if (tick && ctrl_q.run) begin
                presc_q <= presc_q + 8'd1;
            end

            if (wr_en && (word == W_LOAD || word == W_BGLOAD))
                load_q <= wdata;

            if (wr_en && word == W_CLEAR)
                raw_q <= 1'b0;

            if (wr_en && word == W_LOAD) begin
                count_q <= wdata & wmask;
            end else if (step) begin
                if (count_m == '0) begin
                    if (!ctrl_q.oneshot)
                        count_q <= reload_val;
                end else begin
                    count_q <= count_m - 1'b1;
                    if (count_m == {{(DATA_W-1){1'b0}}, 1'b1})
                        raw_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (word)
            W_LOAD, W_BGLOAD: rd_data = load_q;
            W_COUNT:          rd_data = count_q;
            W_CTRL:           rd_data = {{(DATA_W-8){1'b0}}, ctrl_q};
            W_RAW:            rd_data = {{(DATA_W-1){1'b0}}, raw_q};
            W_MASKED:         rd_data = {{(DATA_W-1){1'b0}}, raw_q & ctrl_q.ie};
            default:          rd_data = '0;
        endcase
    end

    assign count = count_q;
    assign irq   = raw_q & ctrl_q.ie;

endmodule

// File: rtl/dt_id_rom.sv
module dt_id_rom
    import dt_pkg::*;
#(
    parameter logic [7:0] PART_ID0 = 8'h04,
    parameter logic [7:0] PART_ID1 = 8'h18,
    parameter logic [7:0] PART_ID2 = 8'h14,
    parameter logic [7:0] PART_ID3 = 8'h00
) (
    input  logic [2:0] idx,
    output logic [7:0] id_byte
);

    localparam logic [31:0] PART_BYTES = {PART_ID3, PART_ID2, PART_ID1, PART_ID0};

    assign id_byte = id_lookup(idx, PART_BYTES);

endmodule

// File: rtl/dt_dual_timer.sv
module dt_dual_timer
    import dt_pkg::*;
#(
    parameter int         N_TIMERS = 2,
    parameter logic [7:0] PART_ID0 = 8'h04,
    parameter logic [7:0] PART_ID1 = 8'h18,
    parameter logic [7:0] PART_ID2 = 8'h14,
    parameter logic [7:0] PART_ID3 = 8'h00
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [N_TIMERS-1:0] tick_en,
    output logic [N_TIMERS-1:0] irq_each,
    output logic                irq_comb
);

    logic [BANK_W-1:0] bank_idx;
    word_e             word;
    logic              id_hit;
    logic [7:0]        id_byte;
    logic              unused_lsbs;

    logic [DATA_W-1:0]                 core_rdata [N_TIMERS];
    logic [N_TIMERS-1:0][DATA_W-1:0]   core_count;

    assign bank_idx    = bus_addr[ADDR_W-1:BANK_LSB];
    assign word        = word_e'(bus_addr[BANK_LSB-1:WORD_LSB]);
    assign id_hit      = (bank_idx == ID_BANK);
    assign unused_lsbs = ^bus_addr[WORD_LSB-1:0];

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_timer
        logic wr_hit;
        assign wr_hit = bus_sel && bus_we && (bank_idx == BANK_W'(i));

        dt_timer_core u_core (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_hit),
            .word    (word),
            .wdata   (bus_wdata),
            .tick    (tick_en[i]),
            .rd_data (core_rdata[i]),
            .count   (core_count[i]),
            .irq     (irq_each[i])
        );
    end

    dt_id_rom #(
        .PART_ID0 (PART_ID0),
        .PART_ID1 (PART_ID1),
        .PART_ID2 (PART_ID2),
        .PART_ID3 (PART_ID3)
    ) u_id (
        .idx     (bus_addr[BANK_LSB-1:WORD_LSB]),
        .id_byte (id_byte)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (id_hit)
                bus_rdata = {{(DATA_W-8){1'b0}}, id_byte};
            for (int i = 0; i < N_TIMERS; i++) begin
                if (bank_idx == BANK_W'(i))
                    bus_rdata = core_rdata[i];
            end
        end
    end

    assign irq_comb = |irq_each;

endmodule

// File: rtl/dt_dual_timer_chk.sv
module dt_dual_timer_chk
    import dt_pkg::*;
#(
    parameter int N_TIMERS = 2
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              bus_sel,
    input logic                              bus_we,
    input logic [ADDR_W-1:0]                 bus_addr,
    input logic [DATA_W-1:0]                 bus_rdata,
    input logic [N_TIMERS-1:0]               tick_en,
    input logic [N_TIMERS-1:0]               irq_each,
    input logic                              irq_comb,
    input logic [N_TIMERS-1:0][DATA_W-1:0]   core_count
);

    logic any_wr;
    logic gap_rd;
    logic id_rd;

    assign any_wr = bus_sel && bus_we;
    assign gap_rd = bus_sel && !bus_we
                    && (bus_addr >= ADDR_W'(WIN_STRIDE * N_TIMERS))
                    && (bus_addr < 12'hFE0);
    assign id_rd  = bus_sel && !bus_we && (bus_addr >= 12'hFE0);

    // R5: gap between the last bank and the identification area reads zero
    assert_gap_zero_R5: assert property (@(posedge clk) disable iff (rst)
        gap_rd |-> (bus_rdata == '0));

    // R4: identification words carry only one byte
    assert_id_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        id_rd |-> (bus_rdata[DATA_W-1:8] == '0));

    // R10: with no write and no tick the combined line cannot move
    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!any_wr && tick_en == '0) |=> $stable(irq_comb));

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_chk
        logic bank_wr;
        logic clr_wr;
        assign bank_wr = any_wr && (bus_addr[ADDR_W-1:BANK_LSB] == BANK_W'(i));
        assign clr_wr  = bank_wr && (bus_addr[BANK_LSB-1:WORD_LSB] == W_CLEAR);

        // R9: count holds without a tick or a write to its own bank (R3)
        assert_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
            (!bank_wr && !tick_en[i]) |=> $stable(core_count[i]));

        // R11: clearing with no tick leaves the line low
        assert_clear_drops_R11: assert property (@(posedge clk) disable iff (rst)
            (clr_wr && !tick_en[i]) |=> !irq_each[i]);

        // R6: an interrupt appears only after a tick or a bus write
        assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
            ($rose(irq_each[i]) && !$past(any_wr)) |-> $past(tick_en[i]));
    end

endmodule

bind dt_dual_timer dt_dual_timer_chk #(.N_TIMERS(N_TIMERS)) u_chk (.*);

// File: tb/dt_dual_timer_test.sv
`timescale 1ns/1ps
module dt_dual_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  tick_en = '0;
    logic [1:0]  irq_each;
    logic        irq_comb;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dt_dual_timer #(
        .N_TIMERS (2),
        .PART_ID0 (8'hA1),
        .PART_ID1 (8'hB2),
        .PART_ID2 (8'hC3),
        .PART_ID3 (8'hD4)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_en   (tick_en),
        .irq_each  (irq_each),
        .irq_comb  (irq_comb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic tick(input logic [1:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_en = m;
        end
        @(negedge clk);
        tick_en = '0;
    endtask

    task automatic irq_chk(input string req, input logic [1:0] each, input logic comb);
        #1;
        check({req, " each"}, {30'b0, irq_each}, {30'b0, each});
        check({req, " comb"}, {31'b0, irq_comb}, {31'b0, comb});
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl0", 12'h008, 32'h20);
        rd_chk("R1 ctrl1", 12'h028, 32'h20);
        rd_chk("R1 load0", 12'h000, 32'h0);
        rd_chk("R1 count1", 12'h024, 32'h0);
        irq_chk("R1 irq", 2'b00, 1'b0);
    endtask

    task automatic t_isolation;
        wr(12'h000, 32'h0000_1234);
        rd_chk("R2 load0", 12'h000, 32'h1234);
        rd_chk("R2 count0", 12'h004, 32'h1234);
        rd_chk("R3 load1 untouched", 12'h020, 32'h0);
        wr(12'h038, 32'h55);
        rd_chk("R2 bgload1 via load", 12'h020, 32'h55);
        rd_chk("R2 bgload1 via bg", 12'h038, 32'h55);
        rd_chk("R2 bgload keeps count1", 12'h024, 32'h0);
        rd_chk("R3 load0 untouched", 12'h000, 32'h1234);
        rd_chk("R3 ctrl0 untouched", 12'h008, 32'h20);
    endtask

    task automatic t_id;
        logic [7:0] exp_id [8] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int k = 0; k < 8; k++)
            rd_chk("R4 id byte", 12'hFE0 + 12'(4 * k), {24'b0, exp_id[k]});
    endtask

    task automatic t_unmapped;
        rd_chk("R5 test ctrl", 12'hF00, 32'h0);
        rd_chk("R5 test out", 12'hF04, 32'h0);
        rd_chk("R5 bank2", 12'h040, 32'h0);
        rd_chk("R5 mid", 12'h7FC, 32'h0);
        rd_chk("R5 below id", 12'hFDC, 32'h0);
        wr(12'hFE0, 32'hFFFF_FFFF);
        rd_chk("R5 id write ignored", 12'hFE0, 32'hA1);
        wr(12'h044, 32'hDEAD);
        wr(12'h040, 32'hBEEF);
        rd_chk("R5 no alias count0", 12'h004, 32'h1234);
        rd_chk("R5 no alias load0", 12'h000, 32'h1234);
        rd_chk("R5 no alias load1", 12'h020, 32'h55);
        rd_chk("R5 bank2 still zero", 12'h040, 32'h0);
    endtask

    task automatic t_prescale;
        wr(12'h000, 32'd3);
        wr(12'h008, 32'h86);
        tick(2'b01, 15);
        rd_chk("R8 /16 before boundary", 12'h004, 32'd3);
        tick(2'b01, 1);
        rd_chk("R8 /16 at boundary", 12'h004, 32'd2);
        wr(12'h008, 32'h82);
        tick(2'b10, 3);
        rd_chk("R9 other tick ignored", 12'h004, 32'd2);
        tick(2'b01, 1);
        rd_chk("R8 /1 step", 12'h004, 32'd1);
    endtask

    task automatic t_irq;
        wr(12'h000, 32'd2);
        wr(12'h008, 32'hE2);
        tick(2'b01, 1);
        rd_chk("R6 step to 1", 12'h004, 32'd1);
        irq_chk("R6 no irq at 1", 2'b00, 1'b0);
        tick(2'b01, 1);
        irq_chk("R10 t0 irq", 2'b01, 1'b1);
        rd_chk("R6 raw0", 12'h010, 32'd1);
        rd_chk("R10 masked0", 12'h014, 32'd1);
        tick(2'b01, 1);
        rd_chk("R7 periodic reload", 12'h004, 32'd2);
        wr(12'h00C, 32'h0);
        irq_chk("R11 clear t0", 2'b00, 1'b0);
        rd_chk("R11 raw0 cleared", 12'h010, 32'd0);
        wr(12'h008, 32'h62);
        wr(12'h020, 32'd1);
        wr(12'h028, 32'hC2);
        tick(2'b10, 1);
        rd_chk("R6 raw1", 12'h030, 32'd1);
        rd_chk("R10 masked1 off", 12'h034, 32'd0);
        irq_chk("R10 masked off", 2'b00, 1'b0);
        wr(12'h028, 32'hE2);
        irq_chk("R10 t1 irq", 2'b10, 1'b1);
        wr(12'h02C, 32'hFFFF_FFFF);
        irq_chk("R11 clear t1", 2'b00, 1'b0);
    endtask

    task automatic t_modes;
        wr(12'h028, 32'h62);
        wr(12'h000, 32'd1);
        wr(12'h008, 32'h80);
        tick(2'b01, 1);
        rd_chk("R7 free16 zero", 12'h004, 32'd0);
        tick(2'b01, 1);
        rd_chk("R7 free16 wrap", 12'h004, 32'h0000_FFFF);
        wr(12'h000, 32'd1);
        wr(12'h008, 32'h81);
        tick(2'b01, 3);
        rd_chk("R7 oneshot holds", 12'h004, 32'd0);
        wr(12'h000, 32'd0);
        wr(12'h008, 32'h82);
        tick(2'b01, 1);
        rd_chk("R7 free32 wrap", 12'h004, 32'hFFFF_FFFF);
        irq_chk("R10 ie off", 2'b00, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_isolation();
        t_id();
        t_unmapped();
        t_prescale();
        t_irq();
        t_modes();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule